// File: doc/BRIEF.md
# Banked Interrupt Controller with Shortcut Reflection

This block gathers 72 level-sensitive interrupt sources into three banks: a basic bank of 8 sources and two peripheral banks of 32 sources each. Every bank has its own enable mask. Software sets bits in the mask through a write-one-to-set register and clears them through a write-one-to-clear register. A pending register per bank shows which enabled sources are currently active. The basic bank's pending word is the first place an interrupt handler looks. Next to the basic sources, it carries one summary bit per peripheral bank and a set of shortcut bits. Each shortcut bit mirrors one chosen peripheral source, so the handler can identify it without reading a second register.

The block drives a registered IRQ line. This line is the OR of every bit in the basic-bank pending word. A registered FIQ line is driven by one source, chosen by a flat index in the FIQ control register. That source is routed whether or not it is enabled for IRQ. All registers sit on a simple word-wide bus. Writes take effect at the clock edge. Read data is registered, so it appears on the cycle after the read strobe.

Top module: `irq_bank_ctrl`

## Requirements
- R1: Register byte offsets are: pending 0x00 (bank 0), 0x04 (bank 1) and 0x08 (bank 2); FIQ control 0x0C; set-enable 0x18 (bank 0), 0x10 (bank 1) and 0x14 (bank 2); clear-enable 0x24 (bank 0), 0x1C (bank 1) and 0x20 (bank 2). Read data is registered and valid on the cycle after `rd_en`. Writes to the pending offsets change nothing.
- R2: A 1 written to a set-enable bit sets that mask bit, and a 1 written to a clear-enable bit clears it. Bits written as 0 leave the mask unchanged. Reading either the set-enable or the clear-enable offset returns the current mask.
- R3: A bank's pending word is its raw sources ANDed with its mask. Bank 0 basic sources occupy pending bits 7:0.
- R4: Bank 0 pending bits 10 to 14 mirror enabled, active bank 1 sources 7, 9, 10, 18 and 19, in that order. Bits 15 to 20 mirror bank 2 sources 21, 22, 23, 24, 25 and 30. A mirrored source also shows in its home bank's pending word.
- R5: Bank 0 pending bit 8 (bank 1) and bit 9 (bank 2) are set only when that bank has an enabled, active source that is not mirrored.
- R6: The bank 0 mask is 8 bits wide. Writes to bank 0 set-enable or clear-enable bits 8 and above are ignored, so the summary bits cannot be masked.
- R7: A mirrored source is masked only through its home bank's registers. Bank 0 enable writes at bits 10 to 20 have no effect on it.
- R8: FIQ control bit 7 enables the FIQ. Bits 6:0 select a flat index: 0 to 31 are bank 1, 32 to 63 are bank 2, 64 to 71 are bank 0, and 72 or more select nothing. Written bits above 7 are dropped and read back as 0. `fiq_out` follows the raw selected source one cycle later, independent of the IRQ mask, so both outputs assert together when that source is also enabled.
- R9: `irq_out` is the OR of all bank 0 pending bits, registered one cycle later.
- R10: After reset, every mask, the FIQ control register, the read data, `irq_out` and `fiq_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_basic | input | 8 | Bank 0 level sources |
| src_per1 | input | 32 | Bank 1 level sources |
| src_per2 | input | 32 | Bank 2 level sources |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Registered interrupt request |
| fiq_out | output | 1 | Registered fast interrupt request |

## Verification
The hardest state to reach from the ports is a bank that holds a mirrored source and a plain source active together. This is the only case where the summary bit and a shortcut bit must both appear and where a clear-enable write must remove exactly one of them. The stimulus enables both kinds of source in bank 1 and then tries to mask the mirrored one through bank 0, which must fail. It then masks the same source through bank 1, which must drop its shortcut while the summary bit stays. A long random phase uses sparse source patterns, so that mirrored and plain sources overlap often. It interleaves writes to every offset, including the pending and out-of-range FIQ indices, and compares a behavioural model on every clock.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int BASIC_N = 8;
  localparam int PER_N   = 32;
  localparam int SC1_N   = 5;
  localparam int SC2_N   = 6;
  localparam int IDX_W   = 7;
  localparam int FLAT_N  = BASIC_N + 2 * PER_N;

  // Mirrored peripheral sources, in bank 0 bit order
  localparam int SC1_SRC [SC1_N] = '{7, 9, 10, 18, 19};
  localparam int SC2_SRC [SC2_N] = '{21, 22, 23, 24, 25, 30};

  localparam int SUM1_BIT = BASIC_N;
  localparam int SUM2_BIT = BASIC_N + 1;
  localparam int SC1_BASE = BASIC_N + 2;
  localparam int SC2_BASE = SC1_BASE + SC1_N;

  localparam logic [7:0] OFF_PEND0 = 8'h00;
  localparam logic [7:0] OFF_PEND1 = 8'h04;
  localparam logic [7:0] OFF_PEND2 = 8'h08;
  localparam logic [7:0] OFF_FIQ   = 8'h0C;
  localparam logic [7:0] OFF_SET1  = 8'h10;
  localparam logic [7:0] OFF_SET2  = 8'h14;
  localparam logic [7:0] OFF_SET0  = 8'h18;
  localparam logic [7:0] OFF_CLR1  = 8'h1C;
  localparam logic [7:0] OFF_CLR2  = 8'h20;
  localparam logic [7:0] OFF_CLR0  = 8'h24;

  function automatic logic [PER_N-1:0] sc1_mask();
    logic [PER_N-1:0] m;
    m = '0;
    for (int k = 0; k < SC1_N; k++) m[SC1_SRC[k]] = 1'b1;
    return m;
  endfunction

  function automatic logic [PER_N-1:0] sc2_mask();
    logic [PER_N-1:0] m;
    m = '0;
    for (int k = 0; k < SC2_N; k++) m[SC2_SRC[k]] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wbits,
  output logic [W-1:0] mask
);
  always_ff @(posedge clk) begin
    if (rst)         mask <= '0;
    else if (set_we) mask <= mask | wbits;
    else if (clr_we) mask <= mask & ~wbits;
  end
endmodule

// File: rtl/irqc_bank_fold.sv
module irqc_bank_fold
  import irqc_pkg::*;
(
  input  logic [PER_N-1:0] src1,
  input  logic [PER_N-1:0] en1,
  input  logic [PER_N-1:0] src2,
  input  logic [PER_N-1:0] en2,
  output logic [PER_N-1:0] pend1,
  output logic [PER_N-1:0] pend2,
  output logic [SC1_N-1:0] sc1,
  output logic [SC2_N-1:0] sc2,
  output logic             sum1,
  output logic             sum2
);
  localparam logic [PER_N-1:0] M1 = sc1_mask();
  localparam logic [PER_N-1:0] M2 = sc2_mask();

  assign pend1 = src1 & en1;
  assign pend2 = src2 & en2;

  for (genvar k = 0; k < SC1_N; k++) begin : g_sc1
    assign sc1[k] = pend1[SC1_SRC[k]];
  end
  for (genvar k = 0; k < SC2_N; k++) begin : g_sc2
    assign sc2[k] = pend2[SC2_SRC[k]];
  end

  // Summary only for sources without a mirror bit
  assign sum1 = |(pend1 & ~M1);
  assign sum2 = |(pend2 & ~M2);
endmodule

// File: rtl/irqc_fiq_pick.sv
module irqc_fiq_pick
  import irqc_pkg::*;
(
  input  logic [BASIC_N-1:0] src0,
  input  logic [PER_N-1:0]   src1,
  input  logic [PER_N-1:0]   src2,
  input  logic [7:0]         ctrl,
  output logic               hit
);
  localparam int SPAN = 2 ** IDX_W;
  localparam int PAD  = SPAN - FLAT_N;

  logic [SPAN-1:0] flat;
  assign flat = {{PAD{1'b0}}, src0, src2, src1};
  assign hit  = ctrl[IDX_W] & flat[ctrl[IDX_W-1:0]];
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irqc_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [BASIC_N-1:0] src_basic,
  input  logic [PER_N-1:0]   src_per1,
  input  logic [PER_N-1:0]   src_per2,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      rdata,
  output logic               irq_out,
  output logic               fiq_out
);
  logic [BASIC_N-1:0] en0;
  logic [PER_N-1:0]   en1, en2, pend1, pend2;
  logic [SC1_N-1:0]   sc1;
  logic [SC2_N-1:0]   sc2;
  logic               sum1, sum2, fiq_hit;
  logic [7:0]         fiq_ctrl;
  logic [DW-1:0]      pend0;

  logic s0, s1, s2, c0, c1, c2, wfiq;
  assign s0   = wr_en && (addr == AW'(OFF_SET0));
  assign s1   = wr_en && (addr == AW'(OFF_SET1));
  assign s2   = wr_en && (addr == AW'(OFF_SET2));
  assign c0   = wr_en && (addr == AW'(OFF_CLR0));
  assign c1   = wr_en && (addr == AW'(OFF_CLR1));
  assign c2   = wr_en && (addr == AW'(OFF_CLR2));
  assign wfiq = wr_en && (addr == AW'(OFF_FIQ));

  irqc_mask_reg #(.W(BASIC_N)) u_en0 (
    .clk(clk), .rst(rst), .set_we(s0), .clr_we(c0),
    .wbits(wdata[BASIC_N-1:0]), .mask(en0));
  irqc_mask_reg #(.W(PER_N)) u_en1 (
    .clk(clk), .rst(rst), .set_we(s1), .clr_we(c1),
    .wbits(wdata[PER_N-1:0]), .mask(en1));
  irqc_mask_reg #(.W(PER_N)) u_en2 (
    .clk(clk), .rst(rst), .set_we(s2), .clr_we(c2),
    .wbits(wdata[PER_N-1:0]), .mask(en2));

  irqc_bank_fold u_fold (
    .src1(src_per1), .en1(en1), .src2(src_per2), .en2(en2),
    .pend1(pend1), .pend2(pend2), .sc1(sc1), .sc2(sc2),
    .sum1(sum1), .sum2(sum2));

  always_comb begin
    pend0 = '0;
    pend0[BASIC_N-1:0] = src_basic & en0;
    pend0[SUM1_BIT] = sum1;
    pend0[SUM2_BIT] = sum2;
    pend0[SC1_BASE +: SC1_N] = sc1;
    pend0[SC2_BASE +: SC2_N] = sc2;
  end

  irqc_fiq_pick u_fiq (
    .src0(src_basic), .src1(src_per1), .src2(src_per2),
    .ctrl(fiq_ctrl), .hit(fiq_hit));

  always_ff @(posedge clk) begin
    if (rst)       fiq_ctrl <= '0;
    else if (wfiq) fiq_ctrl <= wdata[7:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_out <= 1'b0;
      fiq_out <= 1'b0;
    end else begin
      irq_out <= |pend0;
      fiq_out <= fiq_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        AW'(OFF_PEND0): rdata <= pend0;
        AW'(OFF_PEND1): rdata <= DW'(pend1);
        AW'(OFF_PEND2): rdata <= DW'(pend2);
        AW'(OFF_FIQ):   rdata <= DW'(fiq_ctrl);
        AW'(OFF_SET0), AW'(OFF_CLR0): rdata <= DW'(en0);
        AW'(OFF_SET1), AW'(OFF_CLR1): rdata <= DW'(en1);
        AW'(OFF_SET2), AW'(OFF_CLR2): rdata <= DW'(en2);
        default: rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [7:0]         addr,
  input logic [BASIC_N-1:0] src_basic,
  input logic [PER_N-1:0]   src_per1,
  input logic [PER_N-1:0]   src_per2,
  input logic [BASIC_N-1:0] en0,
  input logic [PER_N-1:0]   en1,
  input logic [PER_N-1:0]   en2,
  input logic               fiq_en,
  input logic               sum1_bit,
  input logic               sc_b10,
  input logic               home_b7,
  input logic               irq_out,
  input logic               fiq_out
);
  localparam logic [PER_N-1:0] M1 = sc1_mask();

  // R9: an IRQ needs an enabled, active source one cycle earlier
  a_r9_irq_has_cause: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(|(src_basic & en0) || |(src_per1 & en1) || |(src_per2 & en2)));

  // R5: bank 1 summary needs a plain (non-mirrored) enabled source
  a_r5_summary_plain: assert property (@(posedge clk) disable iff (rst)
    sum1_bit |-> |(src_per1 & en1 & ~M1));

  // R4: mirror bit 10 implies home bank 1 bit 7 pending
  a_r4_shortcut_home: assert property (@(posedge clk) disable iff (rst)
    sc_b10 |-> home_b7);

  // R7: bank 0 enable writes never touch the bank 1 mask
  a_r7_bank0_keeps_home: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == OFF_SET0 || addr == OFF_CLR0)) |=> $stable(en1));

  // R8: FIQ disabled means no FIQ on the next cycle
  a_r8_fiq_gated: assert property (@(posedge clk) disable iff (rst)
    !fiq_en |=> !fiq_out);

  // R10: reset leaves outputs and masks clear
  a_r10_reset_quiet: assert property (@(posedge clk)
    rst |=> (!irq_out && !fiq_out && en1 == '0 && en2 == '0 && en0 == '0));
endmodule

bind irq_bank_ctrl irqc_checker u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
  .src_basic(src_basic), .src_per1(src_per1), .src_per2(src_per2),
  .en0(en0), .en1(en1), .en2(en2), .fiq_en(fiq_ctrl[7]),
  .sum1_bit(pend0[8]), .sc_b10(pend0[10]), .home_b7(pend1[7]),
  .irq_out(irq_out), .fiq_out(fiq_out));

// File: tb/sim_irq_bank_ctrl.sv
module sim_irq_bank_ctrl;
  logic clk = 0, rst = 1;
  logic [7:0]  sb = 0;
  logic [31:0] sp1 = 0, sp2 = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic irq_out, fiq_out;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_bank_ctrl u0 (
    .clk(clk), .rst(rst), .src_basic(sb), .src_per1(sp1), .src_per2(sp2),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_out(irq_out), .fiq_out(fiq_out));

  // ---------------- behavioural reference model ----------------
  int sc1l[5] = '{7, 9, 10, 18, 19};
  int sc2l[6] = '{21, 22, 23, 24, 25, 30};
  logic [7:0]  m_en0, m_fiqc;
  logic [31:0] m_en1, m_en2, m_rd;
  logic m_irq, m_fiq;

  function automatic bit in_list1(int i);
    foreach (sc1l[k]) if (sc1l[k] == i) return 1;
    return 0;
  endfunction
  function automatic bit in_list2(int i);
    foreach (sc2l[k]) if (sc2l[k] == i) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] mpend0();
    logic [31:0] r = 0;
    r[7:0] = sb & m_en0;
    foreach (sc1l[k]) r[10 + k] = sp1[sc1l[k]] & m_en1[sc1l[k]];
    foreach (sc2l[k]) r[15 + k] = sp2[sc2l[k]] & m_en2[sc2l[k]];
    for (int i = 0; i < 32; i++) begin
      if (sp1[i] && m_en1[i] && !in_list1(i)) r[8] = 1;
      if (sp2[i] && m_en2[i] && !in_list2(i)) r[9] = 1;
    end
    return r;
  endfunction

  function automatic logic mfiqv();
    int idx = int'(m_fiqc[6:0]);
    if (!m_fiqc[7]) return 0;
    if (idx < 32) return sp1[idx];
    if (idx < 64) return sp2[idx - 32];
    if (idx < 72) return sb[idx - 64];
    return 0;
  endfunction

  function automatic logic [31:0] mread(logic [7:0] a);
    case (a)
      8'h00: return mpend0();
      8'h04: return sp1 & m_en1;
      8'h08: return sp2 & m_en2;
      8'h0C: return {24'h0, m_fiqc};
      8'h18, 8'h24: return {24'h0, m_en0};
      8'h10, 8'h1C: return m_en1;
      8'h14, 8'h20: return m_en2;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_en0 = 0; m_en1 = 0; m_en2 = 0; m_fiqc = 0; m_rd = 0; m_irq = 0; m_fiq = 0;
    end else begin
      logic ni, nf;
      ni = |mpend0();
      nf = mfiqv();
      if (rd_en) m_rd = mread(addr);
      if (wr_en) begin
        case (addr)
          8'h18: m_en0 = m_en0 | wdata[7:0];
          8'h24: m_en0 = m_en0 & ~wdata[7:0];
          8'h10: m_en1 = m_en1 | wdata;
          8'h1C: m_en1 = m_en1 & ~wdata;
          8'h14: m_en2 = m_en2 | wdata;
          8'h20: m_en2 = m_en2 & ~wdata;
          8'h0C: m_fiqc = wdata[7:0];
          default: ;
        endcase
      end
      m_irq = ni;
      m_fiq = nf;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(irq_out === m_irq, "R9 model irq", {31'h0, irq_out}, {31'h0, m_irq});
      chk(fiq_out === m_fiq, "R8 model fiq", {31'h0, fiq_out}, {31'h0, m_fiq});
      chk(rdata === m_rd, "R1 model rdata", rdata, m_rd);
    end
  end

  // ---------------- bus tasks ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
    chk(rdata === exp, req, rdata, exp);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  localparam logic [7:0] SC_OFFS [10] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10,
                                          8'h14, 8'h18, 8'h1C, 8'h20, 8'h24};

  initial begin
    step(4); rst = 0;
    // R10 reset state
    rd(8'h18, 32'h0, "R10 en0 after reset");
    rd(8'h10, 32'h0, "R10 en1 after reset");
    rd(8'h0C, 32'h0, "R10 fiq ctrl after reset");
    chk(!irq_out && !fiq_out, "R10 outputs after reset", {30'h0, irq_out, fiq_out}, 0);

    // R2 / R6 / R3
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h24, 32'h0000_00FF, "R6 bank0 mask only 8 bits, R2 read via clear offset");
    sb = 8'h81;
    rd(8'h00, 32'h0000_0081, "R3 bank0 pending");
    wr(8'h24, 32'h1);
    rd(8'h00, 32'h0000_0080, "R2 clear-enable bit0");
    wr(8'h18, 32'h0);
    rd(8'h18, 32'h0000_00FE, "R2 zero write keeps mask");
    step(1);
    chk(irq_out === 1'b1, "R9 irq from basic", {31'h0, irq_out}, 1);

    // R4 / R5 shortcut vs summary
    sb = 0;
    wr(8'h10, 32'h0000_0088);
    sp1 = 32'h0000_0080;
    rd(8'h00, 32'h0000_0400, "R4 shortcut bit10 without summary");
    rd(8'h04, 32'h0000_0080, "R4 home bank keeps bit7");
    sp1 = 32'h0000_0088;
    rd(8'h00, 32'h0000_0500, "R5 summary with plain source");
    wr(8'h24, 32'h0000_0400);
    rd(8'h00, 32'h0000_0500, "R7 bank0 clear at shortcut ignored");
    wr(8'h24, 32'h0000_0100);
    rd(8'h00, 32'h0000_0500, "R6 summary not maskable");
    wr(8'h1C, 32'h0000_0080);
    rd(8'h00, 32'h0000_0100, "R7 home bank clear drops shortcut");
    rd(8'h04, 32'h0000_0008, "R3 bank1 pending");

    wr(8'h14, 32'h4000_0001);
    sp2 = 32'h4000_0000;
    rd(8'h00, 32'h0010_0100, "R4 bank2 src30 to bit20");
    rd(8'h08, 32'h4000_0000, "R3 bank2 pending");
    sp2 = 32'h0000_0001;
    rd(8'h00, 32'h0000_0300, "R5 bank2 summary");
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, 32'h0000_0300, "R1 pending write ignored");
    sp1 = 0; sp2 = 0;
    step(2);
    chk(irq_out === 1'b0, "R9 irq idle", {31'h0, irq_out}, 0);

    // R8 FIQ routing
    wr(8'h0C, 32'hFFFF_FF85);
    rd(8'h0C, 32'h0000_0085, "R8 upper ctrl bits dropped");
    sp1 = 32'h0000_0020;
    step(2);
    chk(fiq_out === 1'b1, "R8 fiq bank1 idx5 unmasked", {31'h0, fiq_out}, 1);
    chk(irq_out === 1'b0, "R8 fiq source not on irq", {31'h0, irq_out}, 0);
    wr(8'h0C, 32'h0000_00C2);
    sb = 8'h04;
    step(2);
    chk(fiq_out && irq_out, "R8 both assert idx66", {30'h0, irq_out, fiq_out}, 3);
    wr(8'h0C, 32'h0000_00C8);
    step(2);
    chk(fiq_out === 1'b0, "R8 idx72 selects nothing", {31'h0, fiq_out}, 0);
    sp2 = 32'h0000_0100;
    wr(8'h0C, 32'h0000_00A8);
    step(2);
    chk(fiq_out === 1'b1, "R8 idx40 bank2 src8", {31'h0, fiq_out}, 1);
    wr(8'h0C, 32'h0000_0028);
    step(2);
    chk(fiq_out === 1'b0, "R8 enable bit clear", {31'h0, fiq_out}, 0);

    // random phase, checked against the model each clock
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      sb  = 8'($urandom);
      sp1 = $urandom & $urandom & $urandom;
      sp2 = $urandom & $urandom & $urandom;
      wr_en = 0; rd_en = 0;
      if ($urandom_range(3) == 0) begin
        addr = SC_OFFS[$urandom_range(9)];
        wdata = ($urandom_range(1) == 0) ? $urandom : ($urandom & $urandom);
        if ($urandom_range(1) == 0) wr_en = 1; else rd_en = 1;
      end
    end
    @(negedge clk); wr_en = 0; rd_en = 0;
    step(2);
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule